// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns an IEEE-754 single-precision operand into a signed or unsigned integer of 32 or 64 bits. The fractional part is dropped, so the result is truncated toward zero. A caller places the operand and a 2-bit target selector on the inputs and pulses `start_i`. Exactly two cycles later `done_o` pulses for one cycle. In that same cycle `result_o` and `invalid_o` take the new result and then hold it. A new conversion may start in any cycle, so the unit accepts one operand per clock.

Operands that cannot be represented produce fixed limit values and raise `invalid_o`. Each kind of unrepresentable operand has its own rule: not-a-number, infinity, out-of-range magnitude, and a negative value sent to an unsigned target. A 32-bit result is always presented sign-extended to 64 bits, whether the target is signed or unsigned.

Top module: `flt2int_cvt`

## Requirements
- R1: `mode_i` selects the target: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. An operand that lies in range gives its exact integer value with `invalid_o` low.
- R2: Any fractional part is discarded and the result is rounded toward zero (for example -2.75 gives -2 and 1.5 gives 1), with `invalid_o` low.
- R3: For the two 32-bit targets, bits 63:32 of `result_o` equal bit 31. An unsigned 32-bit value with bit 31 set therefore appears with its upper half all ones.
- R4: For a signed target, a NaN operand of either sign gives the largest positive value of the target width (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF) and raises `invalid_o`.
- R5: For a signed target, an infinite operand or a truncated magnitude outside the target range gives the target minimum when negative and the target maximum when positive, and raises `invalid_o`. An operand equal to exactly -2^(W-1) converts without invalid.
- R6: For an unsigned target, a negative operand other than -0.0 gives 0 and raises `invalid_o`. This covers -infinity and negative values of magnitude below 1. The operand -0.0 gives 0 with `invalid_o` low.
- R7: For an unsigned target, a NaN of either sign, +infinity, or a truncated magnitude above 2^W-1 gives all ones in all 64 bits and raises `invalid_o`.
- R8: An operand of magnitude below 1.0 gives 0 with `invalid_o` low, except in the case covered by R6. This includes both zeros and all subnormals.
- R9: `done_o` is high exactly two cycles after a cycle with `start_i` high and at no other time. `result_o` and `invalid_o` change only in cycles where `done_o` is high.
- R10: While `rst` is high at a clock edge, `result_o`, `invalid_o` and `done_o` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a conversion of the present operand |
| fval_i | input | 32 | Single-precision operand |
| mode_i | input | 2 | Target selector (see R1) |
| result_o | output | 64 | Integer result, 32-bit targets sign-extended |
| invalid_o | output | 1 | Invalid-operation flag for the result |
| done_o | output | 1 | One-cycle pulse when the result is updated |

## Verification
The bench targets the range boundaries. It applies exactly -2^31 and -2^63, which must convert cleanly; a design that compares magnitudes against the positive limit would saturate them and flag invalid. It also applies the largest operand below 2^32 and 2^64 on unsigned targets and the first one above, which catches an off-by-one in the overflow test. NaN is applied to both signed and unsigned targets, because a design that funnels every NaN to the signed maximum would return 0x7FF... where all ones is due. Negative operands below 1 in magnitude and -0.0 are applied to unsigned targets, to tell a sign-based invalid check from a magnitude-based one. Random operands with exponents around the 32- and 64-bit boundaries, under all four selectors, exercise the shifter, the negation and the sign extension.

// File: rtl/flt2int_pkg.sv
package flt2int_pkg;

  // Target selector: bit 0 = unsigned, bit 1 = 64-bit
  typedef enum logic [1:0] {
    CVT_S32 = 2'd0,
    CVT_U32 = 2'd1,
    CVT_S64 = 2'd2,
    CVT_U64 = 2'd3
  } cvt_mode_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_inf;
    logic nonzero;
  } cvt_class_t;

endpackage

// File: rtl/flt2int_unpack.sv
module flt2int_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]       fval_i,
  output flt2int_pkg::cvt_class_t cls_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [MAN_W:0]        sig_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_max;

  assign exp_f   = fval_i[FP_W-2 -: EXP_W];
  assign frac_f  = fval_i[MAN_W-1:0];
  assign exp_max = &exp_f;

  always_comb begin
    cls_o.sign    = fval_i[FP_W-1];
    cls_o.is_nan  = exp_max & (|frac_f);
    cls_o.is_inf  = exp_max & ~(|frac_f);
    cls_o.nonzero = (|exp_f) | (|frac_f);
  end

  assign exp_o = exp_f;
  // hidden bit; subnormals never reach the shifter as they are below one
  assign sig_o = {1'b1, frac_f};

endmodule

// File: rtl/flt2int_align.sv
module flt2int_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 64
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  output logic [INT_W-1:0] mag_o,
  output logic             ovf_o
);

  localparam int XW = EXP_W + 1;
  localparam logic [XW-1:0] BIAS_X = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic [XW-1:0] LIM_X  = BIAS_X + XW'(INT_W);
  localparam logic [XW-1:0] MAN_X  = XW'(MAN_W);

  logic [XW-1:0]    exp_x;
  logic [XW-1:0]    sh;
  logic             below_one;
  logic [INT_W-1:0] sig_w;

  assign exp_x     = {1'b0, exp_i};
  assign below_one = exp_x < BIAS_X;
  assign sh        = exp_x - BIAS_X;
  assign sig_w     = {{(INT_W-MAN_W-1){1'b0}}, sig_i};

  always_comb begin
    ovf_o = 1'b0;
    mag_o = '0;
    if (below_one) begin
      mag_o = '0;
    end else if (exp_x >= LIM_X) begin
      ovf_o = 1'b1;
    end else if (sh <= MAN_X) begin
      mag_o = sig_w >> (MAN_X - sh);
    end else begin
      mag_o = sig_w << (sh - MAN_X);
    end
  end

endmodule

// File: rtl/flt2int_sat.sv
module flt2int_sat #(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  flt2int_pkg::cvt_mode_e  mode_i,
  input  flt2int_pkg::cvt_class_t cls_i,
  input  logic [INT_W-1:0]        mag_i,
  input  logic                    ovf_i,
  output logic [INT_W-1:0]        result_o,
  output logic                    invalid_o
);

  localparam int EXT_W = INT_W - NARROW_W;

  logic signed_tgt, wide;
  logic big, hi_zero;
  logic pos_ovf, neg_ovf, u_ovf;
  logic [INT_W-1:0] s_max, s_min, u_val;

  assign signed_tgt = ~mode_i[0];
  assign wide       = mode_i[1];
  assign big        = ovf_i | cls_i.is_inf;
  assign hi_zero    = ~(|mag_i[INT_W-1:NARROW_W]);

  always_comb begin
    if (wide) begin
      pos_ovf = big | mag_i[INT_W-1];
      neg_ovf = big | (mag_i[INT_W-1] & (|mag_i[INT_W-2:0]));
      u_ovf   = big;
      s_max   = {1'b0, {(INT_W-1){1'b1}}};
      s_min   = {1'b1, {(INT_W-1){1'b0}}};
      u_val   = mag_i;
    end else begin
      pos_ovf = big | ~hi_zero | mag_i[NARROW_W-1];
      neg_ovf = big | ~hi_zero |
                (mag_i[NARROW_W-1] & (|mag_i[NARROW_W-2:0]));
      u_ovf   = big | ~hi_zero;
      s_max   = {{(EXT_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
      s_min   = {{(EXT_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
      u_val   = {{EXT_W{mag_i[NARROW_W-1]}}, mag_i[NARROW_W-1:0]};
    end
  end

  always_comb begin
    invalid_o = 1'b1;
    result_o  = '0;
    if (signed_tgt) begin
      if (cls_i.is_nan) begin
        result_o = s_max;
      end else if (cls_i.sign && neg_ovf) begin
        result_o = s_min;
      end else if (!cls_i.sign && pos_ovf) begin
        result_o = s_max;
      end else begin
        invalid_o = 1'b0;
        result_o  = cls_i.sign ? (~mag_i + 1'b1) : mag_i;
      end
    end else begin
      if (cls_i.is_nan) begin
        result_o = '1;
      end else if (cls_i.sign && cls_i.nonzero) begin
        result_o = '0;
      end else if (u_ovf) begin
        result_o = '1;
      end else begin
        invalid_o = 1'b0;
        result_o  = u_val;
      end
    end
  end

endmodule

// File: rtl/flt2int_cvt.sv
module flt2int_cvt #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  localparam int FP_W    = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [FP_W-1:0]  fval_i,
  input  logic [1:0]       mode_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             done_o
);

  import flt2int_pkg::*;

  cvt_class_t       cls_d, cls_q;
  logic [EXP_W-1:0] exp_d;
  logic [MAN_W:0]   sig_d;
  logic [INT_W-1:0] mag_d, mag_q;
  logic             ovf_d, ovf_q;
  cvt_mode_e        mode_q;
  logic             vld_q;
  logic [INT_W-1:0] res_d;
  logic             inv_d;

  flt2int_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .fval_i (fval_i),
    .cls_o  (cls_d),
    .exp_o  (exp_d),
    .sig_o  (sig_d)
  );

  flt2int_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .exp_i (exp_d),
    .sig_i (sig_d),
    .mag_o (mag_d),
    .ovf_o (ovf_d)
  );

  // stage 1: operand unpacked and magnitude aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      cls_q  <= '0;
      mag_q  <= '0;
      ovf_q  <= 1'b0;
      mode_q <= CVT_S32;
    end else begin
      vld_q <= start_i;
      if (start_i) begin
        cls_q  <= cls_d;
        mag_q  <= mag_d;
        ovf_q  <= ovf_d;
        mode_q <= cvt_mode_e'(mode_i);
      end
    end
  end

  flt2int_sat #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_sat (
    .mode_i    (mode_q),
    .cls_i     (cls_q),
    .mag_i     (mag_q),
    .ovf_i     (ovf_q),
    .result_o  (res_d),
    .invalid_o (inv_d)
  );

  // stage 2: saturated result registered at the outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= vld_q;
      if (vld_q) begin
        result_o  <= res_d;
        invalid_o <= inv_d;
      end
    end
  end

endmodule

// File: rtl/flt2int_cvt_chk.sv
module flt2int_cvt_chk #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  localparam int FP_W    = 1 + EXP_W + MAN_W
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [FP_W-1:0]  fval_i,
  input logic [1:0]       mode_i,
  input logic [INT_W-1:0] result_o,
  input logic             invalid_o,
  input logic             done_o
);

  localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);

  logic [FP_W-1:0] f_q1, f_q2;
  logic [1:0]      m_q1, m_q2;
  logic            nan_q2, neg_nz_q2, small_q2;
  logic [INT_W-1:0] smax_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q1 <= '0; f_q2 <= '0; m_q1 <= '0; m_q2 <= '0;
    end else begin
      f_q1 <= fval_i; f_q2 <= f_q1;
      m_q1 <= mode_i; m_q2 <= m_q1;
    end
  end

  assign nan_q2    = (&f_q2[FP_W-2 -: EXP_W]) & (|f_q2[MAN_W-1:0]);
  assign neg_nz_q2 = f_q2[FP_W-1] & (|f_q2[FP_W-2:0]) & ~nan_q2;
  assign small_q2  = f_q2[FP_W-2 -: EXP_W] < BIAS;
  assign smax_q2   = m_q2[1] ? {1'b0, {(INT_W-1){1'b1}}}
                             : {{(INT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
    start_i |-> ##2 done_o);

  assert_done_origin_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i, 2));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(invalid_o)));

  assert_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !m_q2[1]) |->
      (result_o[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){result_o[NARROW_W-1]}}));

  assert_signed_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !m_q2[0] && nan_q2) |-> (invalid_o && result_o == smax_q2));

  assert_unsigned_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && m_q2[0] && neg_nz_q2) |-> (invalid_o && result_o == '0));

  assert_unsigned_nan_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && m_q2[0] && nan_q2) |-> (invalid_o && (&result_o)));

  assert_below_one_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && small_q2 && !(m_q2[0] && neg_nz_q2)) |->
      (!invalid_o && result_o == '0));

endmodule

bind flt2int_cvt flt2int_cvt_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NARROW_W(NARROW_W)
) u_chk (.*);

// File: tb/flt2int_cvt_bench.sv
`timescale 1ns/1ps
module flt2int_cvt_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] fval_i = '0;
  logic [1:0]  mode_i = '0;
  logic [63:0] result_o;
  logic        invalid_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flt2int_cvt u_flt2int_cvt (
    .clk(clk), .rst(rst), .start_i(start_i), .fval_i(fval_i),
    .mode_i(mode_i), .result_o(result_o), .invalid_o(invalid_o),
    .done_o(done_o)
  );

  // Expected result computed from the requirements with wide integers
  function automatic void ref_cvt(input logic [31:0] f, input logic [1:0] m,
                                  output logic [63:0] r, output logic inv,
                                  output string tag);
    logic        s, nan, inf, zero, huge, sgn, dropped;
    int          e, w;
    logic [127:0] full, mag, lim, val;
    s    = f[31];
    e    = int'(f[30:23]);
    nan  = (e == 255) && (f[22:0] != 0);
    inf  = (e == 255) && (f[22:0] == 0);
    zero = (f[30:0] == 0);
    huge = (e >= 227);
    full = '0; mag = '0; dropped = 1'b0;
    if (e >= 127 && !huge) begin
      full    = {104'b0, 1'b1, f[22:0]} << (e - 127);
      mag     = full >> 23;
      dropped = (full[22:0] != 0);
    end
    w   = m[1] ? 64 : 32;
    sgn = !m[0];
    inv = 1'b0;
    val = '0;
    tag = "R1";
    lim = 128'd1 << (w - 1);
    if (sgn) begin
      if (nan) begin
        val = lim - 1; inv = 1'b1; tag = "R4";
      end else if (inf || huge || (s ? (mag > lim) : (mag > lim - 1))) begin
        val = s ? ~lim + 1 : lim - 1; inv = 1'b1; tag = "R5";
      end else begin
        val = s ? ~mag + 1 : mag;
      end
    end else begin
      if (nan) begin
        val = '1; inv = 1'b1; tag = "R7";
      end else if (s && !zero) begin
        val = '0; inv = 1'b1; tag = "R6";
      end else if (inf || huge || mag > ((128'd1 << w) - 1)) begin
        val = '1; inv = 1'b1; tag = "R7";
      end else begin
        val = mag;
      end
    end
    if (!inv) begin
      if (e < 127)      tag = "R8";
      else if (w == 32) tag = "R3";
      else if (dropped) tag = "R2";
    end
    if (w == 32) r = {{32{val[31]}}, val[31:0]};
    else         r = val[63:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic apply(input logic [31:0] f, input logic [1:0] m);
    logic [63:0] er;
    logic        ei;
    string       tag;
    ref_cvt(f, m, er, ei, tag);
    @(negedge clk);
    fval_i = f; mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R9", "done early", {63'b0, done_o}, 64'd0);
    @(negedge clk);
    check(done_o == 1'b1, "R9", "done at latency 2", {63'b0, done_o}, 64'd1);
    check(result_o == er, tag, $sformatf("result f=%h m=%0d", f, m), result_o, er);
    check(invalid_o == ei, tag, $sformatf("invalid f=%h m=%0d", f, m),
          {63'b0, invalid_o}, {63'b0, ei});
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done one cycle", {63'b0, done_o}, 64'd0);
    check(result_o == er, "R9", "result held", result_o, er);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_v;
    logic [31:0] f;
    seed_v = $urandom(32'h0F2A_1C55);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(result_o == 64'd0, "R10", "result after reset", result_o, 64'd0);
    check(invalid_o == 1'b0, "R10", "invalid after reset", {63'b0, invalid_o}, 64'd0);
    check(done_o == 1'b0, "R10", "done after reset", {63'b0, done_o}, 64'd0);

    // Directed corners (0=s32 1=u32 2=s64 3=u64)
    apply(32'h3F800000, 2'd0);  // R1 1.0
    apply(32'h49742400, 2'd2);  // R1 1e6
    apply(32'hC0300000, 2'd0);  // R2 -2.75 -> -2
    apply(32'h3FC00000, 2'd3);  // R2 1.5 -> 1
    apply(32'h4F3B9ACA, 2'd1);  // R3 ~3.1e9 unsigned, bit31 set
    apply(32'h7FC00000, 2'd0);  // R4 qNaN
    apply(32'hFF800001, 2'd2);  // R4 negative sNaN
    apply(32'hCF000000, 2'd0);  // R5 exact -2^31, clean
    apply(32'h4F000000, 2'd0);  // R5 +2^31 saturates
    apply(32'hCF000001, 2'd0);  // R5 just below -2^31
    apply(32'hDF000000, 2'd2);  // R5 exact -2^63, clean
    apply(32'h5F000000, 2'd2);  // R5 +2^63 saturates
    apply(32'hFF800000, 2'd2);  // R5 -inf
    apply(32'h7F800000, 2'd0);  // R5 +inf
    apply(32'hBF000000, 2'd1);  // R6 -0.5 unsigned
    apply(32'hFF800000, 2'd3);  // R6 -inf unsigned
    apply(32'h80000000, 2'd3);  // R6 -0.0 unsigned, clean
    apply(32'h80000001, 2'd1);  // R6 negative subnormal
    apply(32'h4F7FFFFF, 2'd1);  // R7 largest below 2^32
    apply(32'h4F800000, 2'd1);  // R7 2^32
    apply(32'h5F7FFFFF, 2'd3);  // R7 largest below 2^64
    apply(32'h5F800000, 2'd3);  // R7 2^64
    apply(32'hFFC00000, 2'd3);  // R7 negative NaN
    apply(32'h7F800000, 2'd1);  // R7 +inf
    apply(32'h00000000, 2'd0);  // R8 +0
    apply(32'h007FFFFF, 2'd2);  // R8 subnormal
    apply(32'hBF7FFFFF, 2'd0);  // R8 -0.99 signed
    apply(32'h3F7FFFFF, 2'd1);  // R8 0.99 unsigned

    for (int i = 0; i < 3000; i++) begin
      f = $urandom();
      if (i % 3 != 0) f[30:23] = 8'(120 + ($urandom() % 80));
      apply(f, 2'($urandom()));
    end
    finish_run();
  end

endmodule